// File: doc/BRIEF.md
# Receive Destination Address Classifier

This block looks at the destination address at the head of each received Ethernet frame and decides why the frame should be kept. It raises three flags:
- an individual-match flag when the address equals the programmed station address;
- a hash-match flag when a group address passes a 64-entry hash filter;
- a broadcast flag when the address is all ones.

A frame is accepted when any flag is raised. The flags are valid only in the single cycle that follows the end-of-frame strobe, and they read as zero at every other time.

Frame bytes arrive one per cycle on a byte stream. A start marker comes with the first byte. The first six bytes form the destination address, and the first byte received is the most significant byte of the address. Later bytes of the frame have no effect.

A control input, `bcast_via_hash`, selects how broadcast frames are handled:
- When it is 0, a broadcast frame is accepted unconditionally through the broadcast flag, and the hash filter is not consulted for it.
- When it is 1, the broadcast flag is never raised. A broadcast frame is then accepted only if the hash filter passes the all-ones address, in which case the hash-match flag is raised.

Top module: `rx_addr_match`

## Requirements
- R1: `phys_match` is 1 in a result cycle when all six captured address bytes equal `station_addr`. The first byte received is compared with `station_addr[47:40]` and the sixth with `station_addr[7:0]`.
- R2: For a group address (bit 0 of the first received byte is 1) that is not all ones, `hash_match` equals `hash_filter[idx]`. To form idx, run a CRC-32 (polynomial 0x04C11DB7, register preset to all ones, no final inversion) over the six address bytes, first byte first and each byte least significant bit first. idx is bits [31:26] of the resulting register, with bit 31 as the index MSB.
- R3: With `bcast_via_hash`=0, an all-ones address gives `bcast_match`=1 and `hash_match`=0, whatever the filter contents.
- R4: With `bcast_via_hash`=1, an all-ones address gives `bcast_match`=0, and `hash_match` equals the filter bit selected by the all-ones address as defined in R2.
- R5: An individual address (bit 0 of the first byte is 0) never raises `hash_match`, even with every filter bit set.
- R6: `match_valid` is 1 exactly in the cycle after a cycle in which `rx_eop` is 1.
- R7: All flags and `frame_accept` are 0 whenever `match_valid` is 0.
- R8: In a result cycle, `frame_accept` is the OR of the three flags.
- R9: The address counts only bytes accepted in cycles before the `rx_eop` cycle. If fewer than six have been accepted by then, including when the sixth byte arrives in the `rx_eop` cycle itself, all flags and `frame_accept` are 0.
- R10: A byte marked with `rx_sof` restarts address capture, discarding any partial address. Bytes after the sixth byte of a frame do not change the result.
- R11: After a synchronous reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte strobe for `rx_byte` |
| rx_sof | input | 1 | First byte of a frame, qualified by `rx_valid` |
| rx_byte | input | 8 | Received frame byte |
| rx_eop | input | 1 | End of frame strobe |
| station_addr | input | 48 | Programmed individual address; bits [47:40] are the first byte |
| hash_filter | input | 64 | One enable bit per hash index |
| bcast_via_hash | input | 1 | 1: broadcast frames go through the hash filter only |
| match_valid | output | 1 | Result cycle indication |
| phys_match | output | 1 | Individual address match |
| hash_match | output | 1 | Hash filter match |
| bcast_match | output | 1 | Broadcast address match |
| frame_accept | output | 1 | Frame kept |

## Verification
The bench builds the block with its default parameters: a six-byte address and a six-bit hash index, which together give the full 48-bit comparison and all 64 filter entries. With these values, a frame can end before its address is complete, and the end strobe can coincide with the sixth byte. The bench computes hash indices with a forward-form CRC, so the filter bit that a chosen multicast or broadcast address selects can be set or cleared on purpose.

// File: rtl/rxam_pkg.sv
package rxam_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam logic [31:0] CRC_PRESET    = 32'hFFFF_FFFF;

  typedef struct packed {
    logic phys;
    logic hash;
    logic bcast;
  } rxam_flags_t;

  // One byte of the reflected CRC-32, least significant data bit first.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxam_capture.sv
module rxam_capture #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic [7:0]              in_byte,
  output logic [8*ADDR_BYTES-1:0] addr,
  output logic [HASH_W-1:0]       hash_idx,
  output logic                    complete
);
  import rxam_pkg::*;

  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int CNT_W  = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0] cnt;
  logic [31:0]      crc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      addr <= '0;
      crc  <= CRC_PRESET;
    end else if (in_valid) begin
      if (in_sof) begin
        cnt  <= CNT_W'(1);
        addr <= {{(ADDR_W-8){1'b0}}, in_byte};
        crc  <= crc_step(CRC_PRESET, in_byte);
      end else if (cnt < FULL) begin
        cnt  <= cnt + CNT_W'(1);
        addr <= {addr[ADDR_W-9:0], in_byte};
        crc  <= crc_step(crc, in_byte);
      end
    end
  end

  assign complete = (cnt == FULL);

  // Reflected register bit 0 is the top bit of the forward CRC.
  for (genvar g = 0; g < HASH_W; g++) begin : g_idx
    assign hash_idx[HASH_W-1-g] = crc[g];
  end

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);

endmodule

// File: rtl/rxam_classify.sv
module rxam_classify #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6
) (
  input  logic [8*ADDR_BYTES-1:0] addr,
  input  logic [8*ADDR_BYTES-1:0] station,
  input  logic [HASH_W-1:0]       hash_idx,
  input  logic [(1<<HASH_W)-1:0]  filter,
  input  logic                    complete,
  input  logic                    bcast_via_hash,
  output rxam_pkg::rxam_flags_t   flags
);
  localparam int ADDR_W = 8 * ADDR_BYTES;

  logic [ADDR_BYTES-1:0] byte_eq;
  logic [ADDR_BYTES-1:0] byte_ones;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
    assign byte_eq[g]   = (addr[8*g +: 8] == station[8*g +: 8]);
    assign byte_ones[g] = &addr[8*g +: 8];
  end

  logic is_bcast, is_group, hit;

  assign is_bcast = complete & (&byte_ones);
  assign is_group = complete & addr[ADDR_W-8];
  assign hit      = filter[hash_idx];

  always_comb begin
    flags.phys  = complete & (&byte_eq);
    flags.bcast = is_bcast & ~bcast_via_hash;
    flags.hash  = is_group & hit & (~is_bcast | bcast_via_hash);
  end

endmodule

// File: rtl/rx_addr_match.sv
module rx_addr_match #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic [7:0]              rx_byte,
  input  logic                    rx_eop,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic [(1<<HASH_W)-1:0]  hash_filter,
  input  logic                    bcast_via_hash,
  output logic                    match_valid,
  output logic                    phys_match,
  output logic                    hash_match,
  output logic                    bcast_match,
  output logic                    frame_accept
);
  import rxam_pkg::*;

  localparam int ADDR_W = 8 * ADDR_BYTES;

  logic [ADDR_W-1:0] cap_addr;
  logic [HASH_W-1:0] cap_idx;
  logic              cap_done;
  rxam_flags_t       fl;

  rxam_capture #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W)) u_cap (
    .clk(clk), .rst(rst), .in_valid(rx_valid), .in_sof(rx_sof), .in_byte(rx_byte),
    .addr(cap_addr), .hash_idx(cap_idx), .complete(cap_done)
  );

  rxam_classify #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W)) u_cls (
    .addr(cap_addr), .station(station_addr), .hash_idx(cap_idx), .filter(hash_filter),
    .complete(cap_done), .bcast_via_hash(bcast_via_hash), .flags(fl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      match_valid  <= 1'b0;
      phys_match   <= 1'b0;
      hash_match   <= 1'b0;
      bcast_match  <= 1'b0;
      frame_accept <= 1'b0;
    end else begin
      match_valid  <= rx_eop;
      phys_match   <= rx_eop & fl.phys;
      hash_match   <= rx_eop & fl.hash;
      bcast_match  <= rx_eop & fl.bcast;
      frame_accept <= rx_eop & (fl.phys | fl.hash | fl.bcast);
    end
  end

  assert_valid_after_eop_R6: assert property (@(posedge clk) disable iff (rst)
    rx_eop |=> match_valid);
  assert_valid_cause_R6: assert property (@(posedge clk) disable iff (rst)
    match_valid |-> $past(rx_eop));
  assert_quiet_outside_R7: assert property (@(posedge clk) disable iff (rst)
    !match_valid |-> !(phys_match || hash_match || bcast_match || frame_accept));
  assert_bcast_excludes_hash_R3: assert property (@(posedge clk) disable iff (rst)
    bcast_match |-> !hash_match);
  assert_accept_or_R8: assert property (@(posedge clk) disable iff (rst)
    match_valid |-> (frame_accept == (phys_match || hash_match || bcast_match)));
  assert_individual_no_hash_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_eop && !cap_addr[ADDR_W-8]) |=> !hash_match);

endmodule

// File: tb/rx_addr_match_tb.sv
module rx_addr_match_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        rx_valid, rx_sof, rx_eop;
  logic [7:0]  rx_byte;
  logic [47:0] station_addr;
  logic [63:0] hash_filter;
  logic        bcast_via_hash;
  logic        match_valid, phys_match, hash_match, bcast_match, frame_accept;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_match u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_byte(rx_byte),
    .rx_eop(rx_eop), .station_addr(station_addr), .hash_filter(hash_filter),
    .bcast_via_hash(bcast_via_hash), .match_valid(match_valid), .phys_match(phys_match),
    .hash_match(hash_match), .bcast_match(bcast_match), .frame_accept(frame_accept)
  );

  // Forward-form CRC, data bits least significant first.
  function automatic logic [5:0] hidx(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] b;
      b = a[47-8*k -: 8];
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[31] ^ b[i];
        c  = c << 1;
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    end
    return c[31:26];
  endfunction

  // Behavioural reference model.
  logic [7:0] q[$];
  logic e_v = 0, e_p = 0, e_h = 0, e_b = 0, e_a = 0;

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      e_v = 0; e_p = 0; e_h = 0; e_b = 0; e_a = 0;
    end else begin
      e_v = rx_eop; e_p = 0; e_h = 0; e_b = 0;
      if (rx_eop && q.size() >= 6) begin
        logic [47:0] ma;
        logic bc;
        ma = {q[0], q[1], q[2], q[3], q[4], q[5]};
        bc = (ma == 48'hFFFF_FFFF_FFFF);
        e_p = (ma == station_addr);
        e_b = bc && !bcast_via_hash;
        e_h = q[0][0] && hash_filter[hidx(ma)] && (!bc || bcast_via_hash);
      end
      e_a = e_p || e_h || e_b;
      if (rx_valid) begin
        if (rx_sof) q.delete();
        if (q.size() < 6) q.push_back(rx_byte);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      string tag;
      tests++;
      tag = "";
      if (match_valid !== e_v) tag = "R6";
      else if (!e_v && (phys_match || hash_match || bcast_match || frame_accept)) tag = "R7";
      else if (phys_match !== e_p) tag = "R1";
      else if (hash_match !== e_h) tag = "R2";
      else if (bcast_match !== e_b) tag = "R3";
      else if (frame_accept !== e_a) tag = "R8";
      if (tag != "") begin
        fails++;
        $display("FAIL %s model compare: got v%b p%b h%b b%b a%b expected v%b p%b h%b b%b a%b",
                 tag, match_valid, phys_match, hash_match, bcast_match, frame_accept,
                 e_v, e_p, e_h, e_b, e_a);
      end
    end
  end

  task automatic chk(input string name, input logic [3:0] got, input logic [3:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got phba=%b expected %b", name, got, exp);
    end
  endtask

  // Sends n bytes of address a (then payload), asserting eop with the last byte if eop_with_last.
  task automatic send(input logic [47:0] a, input int n, input bit eop_with_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0);
      rx_byte  = (i < 6) ? a[47-8*i -: 8] : 8'(i * 7);
      rx_eop   = eop_with_last && (i == n - 1);
    end
    if (!eop_with_last) begin
      @(negedge clk);
      rx_valid = 0; rx_sof = 0; rx_eop = 1;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eop = 0;
    #1;
  endtask

  function automatic logic [3:0] res();
    return {phys_match, hash_match, bcast_match, frame_accept};
  endfunction

  bit done = 0;

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] mc;
    logic [47:0] bc;
    mc = 48'h0100_5E00_00FB;
    bc = 48'hFFFF_FFFF_FFFF;
    rst = 1; rx_valid = 0; rx_sof = 0; rx_eop = 0; rx_byte = 0;
    station_addr = 48'h0A1B_2C3D_4E5F; hash_filter = '0; bcast_via_hash = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", res(), 4'b0000);
    tests++;
    if (match_valid !== 1'b0) begin fails++; $display("FAIL R11 match_valid got %b expected 0", match_valid); end
    rst = 0;
    @(negedge clk);

    send(station_addr, 6, 0);
    chk("R1 station match", res(), 4'b1001);
    send(48'h0A1B_2C3D_4E5E, 6, 0);
    chk("R1 last byte differs", res(), 4'b0000);

    hash_filter = 64'd1 << hidx(mc);
    send(mc, 8, 0);
    chk("R2 group hash hit", res(), 4'b0101);
    hash_filter = ~(64'd1 << hidx(mc));
    send(mc, 6, 0);
    chk("R2 group hash miss", res(), 4'b0000);

    hash_filter = '1;
    send(48'h0200_0000_0001, 6, 0);
    chk("R5 individual ignores full filter", res(), 4'b0000);

    bcast_via_hash = 0;
    send(bc, 6, 0);
    chk("R3 broadcast direct", res(), 4'b0011);
    bcast_via_hash = 1;
    hash_filter = 64'd1 << hidx(bc);
    send(bc, 6, 0);
    chk("R4 broadcast via hash hit", res(), 4'b0101);
    hash_filter = ~(64'd1 << hidx(bc));
    send(bc, 6, 0);
    chk("R4 broadcast via hash miss", res(), 4'b0000);
    bcast_via_hash = 0;

    send(station_addr, 3, 0);
    chk("R9 short frame", res(), 4'b0000);
    send(station_addr, 6, 1);
    chk("R9 eop with sixth byte", res(), 4'b0000);

    send(48'hDEAD_BEEF_0000, 3, 1);
    send(station_addr, 20, 0);
    chk("R10 restart and long payload", res(), 4'b1001);

    // Restart in the middle of a frame without an end strobe.
    @(negedge clk); rx_valid = 1; rx_sof = 1; rx_byte = 8'hFF;
    @(negedge clk); rx_sof = 0; rx_byte = 8'hFF;
    send(station_addr, 6, 0);
    chk("R10 sof discards partial", res(), 4'b1001);

    @(negedge clk);
    chk("R7 idle after result", res(), 4'b0000);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule